// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches the bus cycles a processor issues and flags the ones that match a programmed breakpoint. Two independent channels compare every valid cycle against their own condition. A condition is a target address with a don't-care mask, a target data word with its own don't-care mask, and three two-bit qualifiers that pick the bus (primary or secondary), the access kind (instruction fetch or data) and the direction (read or write).

A matching cycle sets a sticky flag in the matching channel. Each channel has one flag for matches on the primary bus and one for matches on the secondary bus. The same match also starts a pulse on a trigger output, and the pulse width is chosen by a global code. The channels share one level-sensitive break request line. That line stays high while any flag is set in a channel whose interrupt-disable bit is clear. Software therefore clears the flags to stop the request.

All registers are written and read through a small register port. The register address has the channel number in its upper bits and a register index in its low three bits.

Top module: `bus_break_unit`

## Requirements
- R1: After reset every register of both channels reads 0, the width code reads 0, `brk_req` is 0 and `trig_out` is 0.
- R2: The address compare ignores each bit position that is 1 in the channel's address mask (index 1) and requires equality with the target address (index 0) in every other position.
- R3: The data compare ignores each bit position that is 1 in the channel's data mask (index 3) and requires equality with the target data (index 2) in every other position.
- R4: The condition register (index 4) has these fields: bits 1:0 select the bus (01 primary, 10 secondary, 11 either), bits 3:2 select the access (01 fetch, 10 data, 11 either) and bits 5:4 select the direction (01 read, 10 write, 11 either). When any of these pairs is 00, the channel never matches.
- R5: A match on a primary-bus cycle (`bus_sec`=0) sets flag bit 0 of the channel's flag register (index 5). A match on a secondary-bus cycle sets flag bit 1. The flag is readable from the cycle after the match.
- R6: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a write of 0 lands in the same cycle as a new match on that bus, the flag stays set.
- R7: A match while `trig_out` is low raises `trig_out` from the next cycle. The pulse lasts 1, 2, 4 or 8 cycles for width codes 00, 01, 10 and 11. The width code is bits 1:0 at index 6 of any channel. A match during an active pulse neither extends nor restarts it.
- R8: When bit 6 of a channel's condition register (interrupt disable) is 1, a match still sets the flag and still fires the pulse, but that channel does not raise `brk_req`.
- R9: `brk_req` is high exactly while some channel has a flag set and its interrupt-disable bit clear. Matches in both channels in the same cycle set both channels' flags on the single request line.
- R10: A secondary-bus instruction fetch (`bus_sec`=1, `bus_fetch`=1) never matches, whatever the condition.
- R11: Registers read back as written, with these exceptions: the condition register keeps bits 6:0 only, the width code keeps bits 1:0 only, and a write of 1 to a clear flag bit reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel number in bit 3, register index in bits 2:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_sec | input | 1 | 0 primary bus, 1 secondary bus |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| brk_req | output | 1 | Level break request |
| trig_out | output | 1 | Trigger pulse output |

## Verification
The bench sets each qualifier pair to 00 in turn, offers a cycle that would otherwise match, and checks that no flag appears. A decoder that tested only one pair, or that treated 00 as "either", would set a flag here. It also sends a secondary-bus fetch, which a design that skipped the fetch exclusion would match, and it measures the trigger width for every code while a second match falls inside an 8-cycle pulse. A counter that restarts, or that is off by one, gives the wrong high-cycle count. The bench also races a flag-clearing write against a new match, where a design that lets the write win drops the flag. Finally, it clears the two channels' flags one at a time and checks that the request falls only when both are clear and ignores a channel whose interrupt is disabled.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // register index inside a channel window
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_ADDR  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_AMASK = 3'd1;
  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DMASK = 3'd3;
  localparam logic [IDX_W-1:0] IDX_COND  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd6;

  localparam int COND_W = 7;
  localparam int CODE_W = 2;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic       int_dis;
    logic [1:0] rw;    // bit0 read, bit1 write
    logic [1:0] acc;   // bit0 fetch, bit1 data
    logic [1:0] bus;   // bit0 primary, bit1 secondary
  } cond_t;

  // trigger pulse length in cycles for a width code
  function automatic logic [CNT_W-1:0] pulse_len(input logic [CODE_W-1:0] code);
    return CNT_W'(1) << code;
  endfunction

  // cycle qualifier check; a 00 pair has no bit set and never passes
  function automatic logic qual_ok(input cond_t c, input logic sec,
                                   input logic fetch, input logic wr);
    logic bus_ok, acc_ok, rw_ok;
    bus_ok = sec ? c.bus[1] : c.bus[0];
    // fetches on the secondary bus are never candidates
    acc_ok = fetch ? (c.acc[0] && !sec) : c.acc[1];
    rw_ok  = wr ? c.rw[1] : c.rw[0];
    return bus_ok && acc_ok && rw_ok;
  endfunction

endpackage

// File: rtl/brk_chan_regs.sv
module brk_chan_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  wdata,
  input  logic              set_p,
  input  logic              set_s,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [ADDR_W-1:0] addr_mask,
  output logic [DATA_W-1:0] tgt_data,
  output logic [DATA_W-1:0] data_mask,
  output cond_t             cond,
  output logic [1:0]        flags,
  output logic [REG_W-1:0]  rdata
);

  logic clr_p, clr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr  <= '0;
      addr_mask <= '0;
      tgt_data  <= '0;
      data_mask <= '0;
      cond      <= '0;
    end else if (we) begin
      case (idx)
        IDX_ADDR:  tgt_addr  <= wdata[ADDR_W-1:0];
        IDX_AMASK: addr_mask <= wdata[ADDR_W-1:0];
        IDX_DATA:  tgt_data  <= wdata[DATA_W-1:0];
        IDX_DMASK: data_mask <= wdata[DATA_W-1:0];
        IDX_COND:  cond      <= cond_t'(wdata[COND_W-1:0]);
        default: ;
      endcase
    end
  end

  // a zero written to a flag bit clears it; a same-cycle match wins
  assign clr_p = we && (idx == IDX_FLAG) && !wdata[0];
  assign clr_s = we && (idx == IDX_FLAG) && !wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= {set_s | (flags[1] & ~clr_s),
                          set_p | (flags[0] & ~clr_p)};
  end

  always_comb begin
    case (idx)
      IDX_ADDR:  rdata = REG_W'(tgt_addr);
      IDX_AMASK: rdata = REG_W'(addr_mask);
      IDX_DATA:  rdata = REG_W'(tgt_data);
      IDX_DMASK: rdata = REG_W'(data_mask);
      IDX_COND:  rdata = REG_W'(cond);
      IDX_FLAG:  rdata = REG_W'(flags);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic [DATA_W-1:0] data_mask,
  input  cond_t             cond,
  input  logic              valid,
  input  logic              sec,
  input  logic              fetch,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_p,
  output logic              hit_s
);

  function automatic logic addr_eq(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] t,
                                   input logic [ADDR_W-1:0] m);
    return ((a ^ t) & ~m) == '0;
  endfunction

  function automatic logic data_eq(input logic [DATA_W-1:0] d,
                                   input logic [DATA_W-1:0] t,
                                   input logic [DATA_W-1:0] m);
    return ((d ^ t) & ~m) == '0;
  endfunction

  logic q_ok, a_ok, d_ok, hit;

  assign q_ok  = qual_ok(cond, sec, fetch, wr);
  assign a_ok  = addr_eq(addr, tgt_addr, addr_mask);
  assign d_ok  = data_eq(data, tgt_data, data_mask);
  assign hit   = valid && q_ok && a_ok && d_ok;
  assign hit_p = hit && !sec;
  assign hit_s = hit && sec;

endmodule

// File: rtl/brk_pulse.sv
module brk_pulse
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              trig
);

  logic [CNT_W-1:0] left;

  // an active pulse runs out; starts are only taken while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (left != '0)   left <= left - CNT_W'(1);
    else if (start)        left <= pulse_len(code);
  end

  assign trig = (left != '0);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W  = CH_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_sec,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              brk_req,
  output logic              trig_out
);

  logic [CH_W-1:0]   reg_ch;
  logic [IDX_W-1:0]  reg_idx;
  logic [CODE_W-1:0] width_code;

  // named internal events, observed by the checker
  logic [NCH-1:0] hit_p_vec, hit_s_vec, hit_vec;
  logic [NCH-1:0] flag_p_vec, flag_s_vec, dis_vec;
  logic           any_hit;
  logic [REG_W-1:0] ch_rdata [NCH];

  assign reg_ch  = reg_addr[RA_W-1:IDX_W];
  assign reg_idx = reg_addr[IDX_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              ch_we;
    logic [ADDR_W-1:0] t_addr, a_mask;
    logic [DATA_W-1:0] t_data, d_mask;
    cond_t             cnd;
    logic [1:0]        flg;

    assign ch_we = reg_we && (reg_ch == CH_W'(c));

    brk_chan_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(ch_we), .idx(reg_idx), .wdata(reg_wdata),
      .set_p(hit_p_vec[c]), .set_s(hit_s_vec[c]),
      .tgt_addr(t_addr), .addr_mask(a_mask), .tgt_data(t_data), .data_mask(d_mask),
      .cond(cnd), .flags(flg), .rdata(ch_rdata[c])
    );

    brk_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
      .tgt_addr(t_addr), .addr_mask(a_mask), .tgt_data(t_data), .data_mask(d_mask),
      .cond(cnd), .valid(bus_valid), .sec(bus_sec), .fetch(bus_fetch), .wr(bus_write),
      .addr(bus_addr), .data(bus_data), .hit_p(hit_p_vec[c]), .hit_s(hit_s_vec[c])
    );

    assign flag_p_vec[c] = flg[0];
    assign flag_s_vec[c] = flg[1];
    assign dis_vec[c]    = cnd.int_dis;
  end

  assign hit_vec = hit_p_vec | hit_s_vec;
  assign any_hit = |hit_vec;

  // global width code, reachable from any channel window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              width_code <= '0;
    else if (reg_we && reg_idx == IDX_CTRL)  width_code <= reg_wdata[CODE_W-1:0];
  end

  always_comb begin
    if (reg_idx == IDX_CTRL)        reg_rdata = REG_W'(width_code);
    else if (int'(reg_ch) < NCH)    reg_rdata = ch_rdata[reg_ch];
    else                            reg_rdata = '0;
  end

  brk_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .start(any_hit), .code(width_code), .trig(trig_out)
  );

  assign brk_req = |((flag_p_vec | flag_s_vec) & ~dis_vec);

endmodule

// File: rtl/brk_checker.sv
module brk_checker
  import brk_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CH_W  = 1,
  parameter int RA_W  = 4,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [RA_W-1:0]  reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             bus_valid,
  input logic             bus_sec,
  input logic             bus_fetch,
  input logic [NCH-1:0]   hit_vec,
  input logic [NCH-1:0]   flag_p_vec,
  input logic [NCH-1:0]   flag_s_vec,
  input logic             any_hit,
  input logic             brk_req,
  input logic             trig_out
);

  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (trig_out) run_len <= run_len + 8'd1;
    else               run_len <= '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic zero_p, zero_s;
    assign zero_p = reg_we && (reg_addr == {CH_W'(c), IDX_FLAG}) && !reg_wdata[0];
    assign zero_s = reg_we && (reg_addr == {CH_W'(c), IDX_FLAG}) && !reg_wdata[1];

    assert_flag_set_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_sec && hit_vec[c]) |=> flag_p_vec[c]);

    assert_flag_set_s_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_sec && hit_vec[c]) |=> flag_s_vec[c]);

    assert_sticky_p_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_p_vec[c] && !zero_p) |=> flag_p_vec[c]);

    assert_sticky_s_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_s_vec[c] && !zero_s) |=> flag_s_vec[c]);

    assert_sec_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_sec && bus_fetch) |-> !hit_vec[c]);
  end

  assert_req_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_p_vec == '0 && flag_s_vec == '0) |-> !brk_req);

  assert_trig_from_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(any_hit));

  assert_trig_max_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (run_len < 8'd8));

endmodule

bind bus_break_unit brk_checker #(.NCH(NCH), .CH_W(CH_W), .RA_W(RA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .bus_valid(bus_valid), .bus_sec(bus_sec), .bus_fetch(bus_fetch),
  .hit_vec(hit_vec), .flag_p_vec(flag_p_vec), .flag_s_vec(flag_s_vec),
  .any_hit(any_hit), .brk_req(brk_req), .trig_out(trig_out)
);

// File: tb/tb_bus_break_unit.sv
module tb_bus_break_unit;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0, bus_sec = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        brk_req, trig_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_break_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_sec(bus_sec), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_data(bus_data), .brk_req(brk_req), .trig_out(trig_out)
  );

  typedef struct packed {
    logic [31:0] tgt;
    logic [31:0] amask;
    logic [31:0] tdat;
    logic [31:0] dmask;
    logic [6:0]  cond;
    logic        sec;
    logic        fetch;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R2 address compare
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b01, 4'd2},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F, 1'b0, 1'b0, 1'b0, 32'h1010, 32'h0, 2'b00, 4'd2},
    '{32'h1000, 32'hFF, 32'h0, 32'hFFFFFFFF, 7'h3F, 1'b0, 1'b0, 1'b0, 32'h10F0, 32'h0, 2'b01, 4'd2},
    // R3 data compare
    '{32'h1000, 32'h0, 32'hAB, 32'hFFFFFF00, 7'h3F, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h123456AB, 2'b01, 4'd3},
    '{32'h1000, 32'h0, 32'hAB, 32'hFFFFFF00, 7'h3F, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h123456AC, 2'b00, 4'd3},
    '{32'h1000, 32'h0, 32'hAB, 32'h0, 7'h3F, 1'b0, 1'b0, 1'b1, 32'h1000, 32'hAB, 2'b01, 4'd3},
    // R4 qualifiers, R5 bus flag
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3D, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b00, 4'd4},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3E, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b10, 4'd5},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F, 1'b1, 1'b0, 1'b1, 32'h1000, 32'h0, 2'b10, 4'd5},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h1F, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h0, 2'b00, 4'd4},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h0F, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b00, 4'd4},
    // R10 secondary fetch
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F, 1'b1, 1'b1, 1'b0, 32'h1000, 32'h0, 2'b00, 4'd10},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h37, 1'b0, 1'b1, 1'b0, 32'h1000, 32'h0, 2'b01, 4'd4},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h33, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b00, 4'd4},
    '{32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3C, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h0, 2'b00, 4'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input int idx, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(ch * 8 + idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input int idx, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(ch * 8 + idx);
    #1 v = reg_rdata;
  endtask

  task automatic bus_cyc(input logic s, input logic f, input logic w,
                         input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_sec = s; bus_fetch = f; bus_write = w; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] t, input logic [31:0] am,
                      input logic [31:0] td, input logic [31:0] dm, input logic [6:0] c);
    wr_reg(ch, 0, t); wr_reg(ch, 1, am); wr_reg(ch, 2, td); wr_reg(ch, 3, dm);
    wr_reg(ch, 4, 32'(c));
  endtask

  task automatic count_trig(input int span, output int hi);
    hi = 0;
    for (int i = 0; i < span; i++) begin
      if (trig_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int idx = 0; idx < 7; idx++) begin
        rd_reg(ch, idx, v);
        chk($sformatf("R1 reg ch%0d idx%0d", ch, idx), v, 32'h0);
      end
    chk("R1 brk_req", 32'(brk_req), 32'h0);
    chk("R1 trig_out", 32'(trig_out), 32'h0);

    // R11 readback
    wr_reg(1, 0, 32'hDEADBEEF); rd_reg(1, 0, v); chk("R11 addr readback", v, 32'hDEADBEEF);
    wr_reg(1, 3, 32'h5A5A0F0F); rd_reg(1, 3, v); chk("R11 dmask readback", v, 32'h5A5A0F0F);
    wr_reg(1, 4, 32'hFFFFFFC0); rd_reg(1, 4, v); chk("R11 cond bits 6:0", v, 32'h40);
    wr_reg(1, 4, 32'h0);
    wr_reg(0, 6, 32'hFFFFFFFE); rd_reg(1, 6, v); chk("R11 ctrl bits 1:0", v, 32'h2);
    wr_reg(0, 5, 32'h3); rd_reg(0, 5, v); chk("R11 flag write 1 no set", v, 32'h0);
    wr_reg(0, 6, 32'h0);

    // table walk on channel 0 (R2 R3 R4 R5 R10)
    for (int k = 0; k < NV; k++) begin
      prog(0, VECS[k].tgt, VECS[k].amask, VECS[k].tdat, VECS[k].dmask, VECS[k].cond);
      wr_reg(0, 5, 32'h0);
      bus_cyc(VECS[k].sec, VECS[k].fetch, VECS[k].wr, VECS[k].addr, VECS[k].data);
      rd_reg(0, 5, v);
      chk($sformatf("R%0d vec %0d flags", VECS[k].tag, k), v, 32'(VECS[k].exp));
      chk($sformatf("R9 vec %0d req", k), 32'(brk_req), 32'(|VECS[k].exp));
      wr_reg(0, 5, 32'h0);
      repeat (2) @(negedge clk);
    end

    // R7 pulse widths per code
    prog(0, 32'h2000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F);
    for (int code = 0; code < 4; code++) begin
      wr_reg(0, 6, 32'(code));
      bus_cyc(1'b0, 1'b0, 1'b0, 32'h2000, 32'h0);
      count_trig(12, hi);
      chk($sformatf("R7 width code %0d", code), 32'(hi), 32'(1 << code));
      wr_reg(0, 5, 32'h0);
    end

    // R7 no restart: second match inside an 8-cycle pulse
    @(negedge clk);
    bus_valid = 1'b1; bus_sec = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0;
    bus_addr = 32'h2000; bus_data = 32'h0;
    hi = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i == 0) bus_valid = 1'b0;
      if (i == 3) bus_valid = 1'b1;
      if (i == 4) bus_valid = 1'b0;
      if (trig_out) hi++;
    end
    chk("R7 no restart total high", 32'(hi), 32'd8);
    wr_reg(0, 6, 32'h0);

    // R6 sticky flag and clear rules
    wr_reg(0, 5, 32'h0);
    bus_cyc(1'b0, 1'b0, 1'b0, 32'h2000, 32'h0);
    repeat (5) @(negedge clk);
    rd_reg(0, 5, v); chk("R6 flag sticky", v, 32'h1);
    chk("R9 req while flag", 32'(brk_req), 32'h1);
    wr_reg(0, 5, 32'h1); rd_reg(0, 5, v); chk("R6 write 1 keeps flag", v, 32'h1);
    // clearing write racing a new match
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h0;
    bus_valid = 1'b1; bus_sec = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0;
    bus_addr = 32'h2000; bus_data = 32'h0;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    rd_reg(0, 5, v); chk("R6 match beats clear", v, 32'h1);
    wr_reg(0, 5, 32'h0); rd_reg(0, 5, v); chk("R6 write 0 clears", v, 32'h0);
    chk("R9 req drops after clear", 32'(brk_req), 32'h0);

    // R8 interrupt disable
    wr_reg(0, 4, 32'h7F);
    bus_cyc(1'b0, 1'b0, 1'b0, 32'h2000, 32'h0);
    chk("R8 trig fires", 32'(trig_out), 32'h1);
    chk("R8 no request", 32'(brk_req), 32'h0);
    rd_reg(0, 5, v); chk("R8 flag set", v, 32'h1);
    wr_reg(0, 5, 32'h0);

    // R9 two channels merged
    wr_reg(0, 4, 32'h3F);
    prog(1, 32'h2000, 32'h0, 32'h0, 32'hFFFFFFFF, 7'h3F);
    bus_cyc(1'b0, 1'b0, 1'b0, 32'h2000, 32'h0);
    rd_reg(0, 5, v); chk("R9 ch0 flag", v, 32'h1);
    rd_reg(1, 5, v); chk("R9 ch1 flag", v, 32'h1);
    chk("R9 req both", 32'(brk_req), 32'h1);
    wr_reg(0, 5, 32'h0);
    chk("R9 req ch1 only", 32'(brk_req), 32'h1);
    wr_reg(1, 4, 32'h7F);
    chk("R9 req ch1 disabled", 32'(brk_req), 32'h0);
    wr_reg(1, 4, 32'h3F);
    chk("R9 req ch1 re-enabled", 32'(brk_req), 32'h1);
    wr_reg(1, 5, 32'h0);
    chk("R9 req none", 32'(brk_req), 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule